// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Bank

This block is a small register-mapped unit that owns ten bidirectional general-purpose pins and watches five internal event lines. The five lines are a conversion-ready flag, a positive and a negative touch-sense comparator, a telecom clip detector and an audio clip detector. A host reaches the unit through a plain synchronous register port with an address, write data, a write strobe and combinational read data. Through this port the host sets pin levels and directions, chooses which edges raise interrupts, clears interrupts, and reads status.

Every pin and event line passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. Each interrupt source has a two-state machine with the states SRC_IDLE and SRC_PEND.
- The transition SRC_IDLE to SRC_PEND ("hit") is taken on a rising edge whose rise-enable bit is 1, or on a falling edge whose fall-enable bit is 1.
- The transition SRC_PEND to SRC_IDLE ("clear") is taken when a write to the interrupt register turns the source's clear bit from 0 to 1 compared with the previous write to that register, and no hit occurs in the same cycle.
- In every other case the machine stays in its state ("hold").

The single interrupt output is the OR of all pending sources. The top bit of the direction register is passed out as a control that chooses how a serial data line behaves during the second word of a frame.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register holds 0. pin_oe, pin_out, irq and frame_hold_low are all 0, and reading address 4 returns 0.
- R2: pin_out[i] equals bit i of the data register (address 0). pin_oe[i] equals bit i of the direction register (address 1). A 1 in the direction register makes the pin an output.
- R3: Reading address 0 returns in bits 9:0 the synchronized level of each pin, whatever its direction, with bits 15:10 at 0. A level change is visible after two clock edges.
- R4: Addresses 1, 2 and 3 read back what was written, with these exceptions. Bit 10 always reads 0. In the direction register bits 14:10 read 0 and bit 15 is kept.
- R5: Bit map of the rise-enable, fall-enable and interrupt registers: bits 9:0 are pins 9:0. Bit 11 is evt_in[0] (conversion ready), bit 12 is evt_in[1] (positive touch), bit 13 is evt_in[2] (negative touch), bit 14 is evt_in[3] (telecom clip) and bit 15 is evt_in[4] (audio clip).
- R6: A rising edge sets a source's status bit only when its rise-enable bit is 1. A falling edge sets it only when its fall-enable bit is 1.
- R7: A write to address 4 clears status bit i only if bit i of the written data is 1 and bit i of the previous write to address 4 was 0. Writing 1 again over a 1 leaves the bit set.
- R8: If a qualifying edge and a clearing write hit the same source in the same cycle, the status bit stays set.
- R9: irq is 1 exactly when at least one status bit is set.
- R10: frame_hold_low equals bit 15 of the direction register. A 1 means the serial line is held low during the second word of a frame, and a 0 means it is left floating.
- R11: A source change first sampled at clock edge k sets the status bit at edge k+2. It reads 0 before that edge and 1 after it.
- R12: Reads of addresses 5 to 7 return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Combinational read data |
| pin_in | input | 10 | Sensed level of each pin |
| pin_out | output | 10 | Value driven on output pins |
| pin_oe | output | 10 | Output enable per pin |
| evt_in | input | 5 | Event lines: ready, touch+, touch-, telecom clip, audio clip |
| frame_hold_low | output | 1 | Serial line hold-low select |
| irq | output | 1 | Combined interrupt |

## Verification
The edge machinery is driven with rising-only, falling-only and both-edge enable masks on the same pin. This separates a correct edge-polarity gate from one that ignores a mask or swaps the two masks. Each event line is toggled alone and its status bit is checked, which exposes any bit-map shift.

Clearing is exercised in three ways: a 0-to-1 write, a repeated 1 write, and a clear that lands in the same cycle as a new edge. These cases tell transition-based clearing apart from level-based clearing and from a clear that wins the collision. One edge is sampled cycle by cycle to pin down the synchronizer depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_t;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_DIR  = 3'd1;
    localparam logic [2:0] A_RISE = 3'd2;
    localparam logic [2:0] A_FALL = 3'd3;
    localparam logic [2:0] A_IRQ  = 3'd4;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic pend
);
    src_state_t state_q;
    src_state_t state_d;
    logic       hit;

    assign hit = (rise & rise_en) | (fall & fall_en);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (hit)         state_d = SRC_PEND;
            SRC_PEND: if (clr && !hit) state_d = SRC_IDLE;
            default:                   state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == SRC_PEND);
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 10,
    parameter int DW   = 16
) (
    input  logic [2:0]      addr,
    input  logic [NPIN-1:0] level,
    input  logic [NPIN-1:0] data,
    input  logic [NPIN-1:0] dir,
    input  logic            hold_low,
    input  logic [DW-1:0]   ren,
    input  logic [DW-1:0]   fen,
    input  logic [DW-1:0]   stat,
    output logic [DW-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DATA: rdata[NPIN-1:0] = level;
            A_DIR: begin
                rdata[NPIN-1:0] = dir;
                rdata[DW-1]     = hold_low;
            end
            A_RISE:  rdata = ren;
            A_FALL:  rdata = fen;
            A_IRQ:   rdata = stat;
            default: rdata = '0;
        endcase
    end

    // Data register is write-only as seen from the bus; kept as a port
    // so the mux has one view of all stored state.
    logic unused_data;
    assign unused_data = ^data;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPIN     = 10,
    parameter int NEVT     = 5,
    parameter int EVT_BASE = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  reg_addr,
    input  logic [EVT_BASE+NEVT-1:0]    reg_wdata,
    input  logic                        reg_we,
    output logic [EVT_BASE+NEVT-1:0]    reg_rdata,
    input  logic [NPIN-1:0]             pin_in,
    output logic [NPIN-1:0]             pin_out,
    output logic [NPIN-1:0]             pin_oe,
    input  logic [NEVT-1:0]             evt_in,
    output logic                        frame_hold_low,
    output logic                        irq
);
    localparam int DW = EVT_BASE + NEVT;
    localparam logic [DW-1:0] PIN_MASK = DW'((64'd1 << NPIN) - 64'd1);
    localparam logic [DW-1:0] EVT_MASK = DW'(((64'd1 << NEVT) - 64'd1) << EVT_BASE);
    localparam logic [DW-1:0] VALID    = PIN_MASK | EVT_MASK;

    logic [NPIN-1:0] data_q;
    logic [NPIN-1:0] dir_q;
    logic            hold_q;
    logic [DW-1:0]   ren_q;
    logic [DW-1:0]   fen_q;
    logic [DW-1:0]   clrw_q;

    logic [DW-1:0]   src_raw;
    logic [DW-1:0]   src_lvl;
    logic [DW-1:0]   src_rise;
    logic [DW-1:0]   src_fall;
    logic [DW-1:0]   clr_pulse;
    logic [DW-1:0]   stat_w;
    logic            wr_irq;

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            hold_q <= 1'b0;
            ren_q  <= '0;
            fen_q  <= '0;
            clrw_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                A_DATA: data_q <= reg_wdata[NPIN-1:0];
                A_DIR: begin
                    dir_q  <= reg_wdata[NPIN-1:0];
                    hold_q <= reg_wdata[DW-1];
                end
                A_RISE: ren_q  <= reg_wdata & VALID;
                A_FALL: fen_q  <= reg_wdata & VALID;
                A_IRQ:  clrw_q <= reg_wdata & VALID;
                default: ;
            endcase
        end
    end

    // Clear fires on a 0-to-1 change against the previous clear-register write
    assign wr_irq    = reg_we && (reg_addr == A_IRQ);
    assign clr_pulse = wr_irq ? (reg_wdata & ~clrw_q & VALID) : '0;

    // Source vector assembly
    always_comb begin
        src_raw = '0;
        src_raw[NPIN-1:0]          = pin_in;
        src_raw[EVT_BASE +: NEVT]  = evt_in;
    end

    gpio_sync_edge #(.WIDTH(DW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (src_raw),
        .level (src_lvl),
        .rise  (src_rise),
        .fall  (src_fall)
    );

    for (genvar i = 0; i < DW; i++) begin : g_src
        if (VALID[i]) begin : g_cell
            gpio_irq_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .rise    (src_rise[i]),
                .fall    (src_fall[i]),
                .rise_en (ren_q[i]),
                .fall_en (fen_q[i]),
                .clr     (clr_pulse[i]),
                .pend    (stat_w[i])
            );
        end else begin : g_none
            assign stat_w[i] = 1'b0;
        end
    end

    gpio_read_mux #(.NPIN(NPIN), .DW(DW)) u_rmux (
        .addr     (reg_addr),
        .level    (src_lvl[NPIN-1:0]),
        .data     (data_q),
        .dir      (dir_q),
        .hold_low (hold_q),
        .ren      (ren_q),
        .fen      (fen_q),
        .stat     (stat_w),
        .rdata    (reg_rdata)
    );

    assign pin_out        = data_q;
    assign pin_oe         = dir_q;
    assign frame_hold_low = hold_q;
    assign irq            = |stat_w;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NPIN = 10,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [NPIN-1:0] pin_oe,
    input  logic            frame_hold_low,
    input  logic            irq,
    input  logic [DW-1:0]   stat,
    input  logic [DW-1:0]   ren,
    input  logic [DW-1:0]   fen
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && !irq && !frame_hold_low));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd1) |=> (pin_oe == $past(reg_wdata[NPIN-1:0])));

    p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd1) |=> (frame_hold_low == $past(reg_wdata[DW-1])));

    p_set_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~($past(ren) | $past(fen))) == '0));

    p_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat) & ~stat) != '0) |-> $past(reg_we && reg_addr == 3'd4));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .DW(EVT_BASE + NEVT)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .pin_oe         (pin_oe),
    .frame_hold_low (frame_hold_low),
    .irq            (irq),
    .stat           (stat_w),
    .ren            (ren_q),
    .fen            (fen_q)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic [9:0]  pin_ext = '0;
    logic [9:0]  pin_pad;
    logic [9:0]  pin_out;
    logic [9:0]  pin_oe;
    logic [4:0]  evt_in = '0;
    logic        frame_hold_low;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    assign pin_pad = (pin_oe & pin_out) | (~pin_oe & pin_ext);

    gpio_irq_bank u_gpio_irq_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_we         (reg_we),
        .reg_rdata      (reg_rdata),
        .pin_in         (pin_pad),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .evt_in         (evt_in),
        .frame_hold_low (frame_hold_low),
        .irq            (irq)
    );

    // addr[34:32] | wdata[31:16] | expected readback[15:0]
    localparam logic [34:0] VEC [7] = '{
        {3'd1, 16'hFFFF, 16'h83FF},
        {3'd2, 16'hFFFF, 16'hFBFF},
        {3'd3, 16'h5555, 16'h5155},
        {3'd5, 16'hFFFF, 16'h0000},
        {3'd1, 16'h0000, 16'h0000},
        {3'd2, 16'h0000, 16'h0000},
        {3'd3, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [34:0] e;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd4, v);   chk("R1 status", v, 16'h0000);
        chk("R1 outputs", {4'b0, irq, frame_hold_low, pin_oe}, 16'h0000);
        chk("R1 pin_out", {6'b0, pin_out}, 16'h0000);
        rd(3'd2, v);   chk("R1 rise enable", v, 16'h0000);

        // R4/R10/R12 table walk
        for (int i = 0; i < 7; i++) begin
            e = VEC[i];
            wr(e[34:32], e[31:16]);
            rd(e[34:32], v);
            chk("R4/R12 readback", v, e[15:0]);
            if (e[34:32] == 3'd1) begin
                chk("R10 hold", {15'b0, frame_hold_low}, {15'b0, e[15]});
                chk("R2 oe", {6'b0, pin_oe}, {6'b0, e[25:16]});
            end
        end

        // R3 pin level readback, inputs and outputs
        pin_ext = 10'h2A5;
        idle(3);
        rd(3'd0, v);   chk("R3 input levels", v, 16'h02A5);
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h0003);
        chk("R2 pin_out", {6'b0, pin_out}, 16'h0002);
        chk("R2 pin_oe", {6'b0, pin_oe}, 16'h0003);
        idle(3);
        rd(3'd0, v);   chk("R3 driven levels", v, 16'h02A6);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0000);
        pin_ext = 10'h000;
        idle(4);
        rd(3'd4, v);   chk("R6 no enable no status", v, 16'h0000);

        // R11 latency on pin 4
        wr(3'd2, 16'h0010);
        @(negedge clk); pin_ext[4] = 1'b1;
        rd(3'd4, v);   chk("R11 after edge k", v, 16'h0000);
        rd(3'd4, v);   chk("R11 after edge k+1", v, 16'h0000);
        rd(3'd4, v);   chk("R11 after edge k+2", v, 16'h0010);
        chk("R9 irq set", {15'b0, irq}, 16'h0001);

        // R7 clear on 0->1, not on 1->1
        wr(3'd4, 16'h0010);
        rd(3'd4, v);   chk("R7 clear 0to1", v, 16'h0000);
        chk("R9 irq clear", {15'b0, irq}, 16'h0000);
        pin_ext[4] = 1'b0; idle(4);
        pin_ext[4] = 1'b1; idle(4);
        rd(3'd4, v);   chk("R6 rise relatch", v, 16'h0010);
        wr(3'd4, 16'h0010);
        rd(3'd4, v);   chk("R7 repeat one keeps", v, 16'h0010);
        wr(3'd4, 16'h0000);
        wr(3'd4, 16'h0010);
        rd(3'd4, v);   chk("R7 clear after zero", v, 16'h0000);
        wr(3'd4, 16'h0000);

        // R6 polarity masks on pin 4
        pin_ext[4] = 1'b0; idle(4);
        rd(3'd4, v);   chk("R6 fall without enable", v, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0010);
        pin_ext[4] = 1'b1; idle(4);
        rd(3'd4, v);   chk("R6 rise without enable", v, 16'h0000);
        pin_ext[4] = 1'b0; idle(4);
        rd(3'd4, v);   chk("R6 fall enabled", v, 16'h0010);
        wr(3'd4, 16'h0010); wr(3'd4, 16'h0000);
        wr(3'd3, 16'h0000);

        // R5 event bit map
        wr(3'd2, 16'hF800);
        for (int j = 0; j < 5; j++) begin
            evt_in[j] = 1'b1; idle(4);
            rd(3'd4, v);
            chk("R5 event bit", v, 16'(1) << (11 + j));
            wr(3'd4, 16'hF800); wr(3'd4, 16'h0000);
            evt_in[j] = 1'b0; idle(4);
        end
        wr(3'd2, 16'h0000);

        // R8 edge and clear collide on pin 5
        wr(3'd2, 16'h0020);
        wr(3'd3, 16'h0020);
        pin_ext[5] = 1'b1; idle(4);
        rd(3'd4, v);   chk("R8 setup", v, 16'h0020);
        @(negedge clk); pin_ext[5] = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_addr = 3'd4; reg_wdata = 16'h0020; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        rd(3'd4, v);   chk("R8 edge wins", v, 16'h0020);
        wr(3'd4, 16'h0000);
        wr(3'd4, 16'h0020);
        rd(3'd4, v);   chk("R8 later clear", v, 16'h0000);
        chk("R9 irq low", {15'b0, irq}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule